// File: doc/BRIEF.md
# Condition Flag and Predicate Unit

This block keeps three one-bit condition flags for a programmable port controller: two general-purpose flags, A and B, and a control flag, C. The sequencer that runs instructions asks it, every cycle, whether a two-bit predicate code holds against the current flags. The answer comes back combinationally on `pred_true`, so the sequencer can gate the instruction it holds in the same cycle.

The unit also performs flag-update instructions. Each update carries one six-bit selection mask per flag. The new value of a flag is the OR of the mask-selected terms, drawn from the three current flags and their complements. All three new values are computed from the flags as they stood before the update, and all three are written on the same clock edge.

An update takes effect only when its predicate holds. Apart from updates, C can be loaded from outside the unit. A port that carries data toward the switch fabric takes C from the attached functional unit. A port that receives data takes C from a spare bit of the destination address of the arriving packet. The parameter `IN_DIR` selects between these two sources at elaboration time.

Top module: `cond_flag_unit`

## Requirements
- R1: While `rst_n` is low, flags A, B and C are all 0.
- R2: `pred_true` is a combinational function of the current flags. Code 2'b00 gives A, 2'b10 gives B, 2'b01 gives C, and 2'b11 gives constant 1.
- R3: When `upd_valid` is high and `pred_true` is 1, each flag takes, at the next rising edge, the OR of the terms its mask selects. Mask bit 0 selects A, bit 1 selects not-A, bit 2 selects B, bit 3 selects not-B, bit 4 selects C, and bit 5 selects not-C.
- R4: An effective update whose mask for a flag is all zeros writes 0 to that flag.
- R5: An effective update whose mask selects a flag together with its complement writes 1.
- R6: An effective update in which each flag's mask selects only that same flag leaves all three flags unchanged.
- R7: An update is ignored in either of two cases: `upd_valid` is low, or `pred_true` is 0 in that cycle. A flag does not change in response to an ignored update.
- R8: All three new values are computed from the flag values that held before the edge. For example, masks A←B and B←A swap the two flags.
- R9: When `ext_c_load` is high and no effective update occurs, C takes the external source at the next edge, and A and B are unchanged. With `IN_DIR`=1 the source is `rx_dest[C_BIT]`; with `IN_DIR`=0 it is `ship_c`.
- R10: When an effective update and `ext_c_load` occur in the same cycle, the update decides the new value of C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pred_code | input | 2 | Predicate code to evaluate |
| pred_true | output | 1 | Predicate result against current flags |
| upd_valid | input | 1 | Flag-update instruction strobe |
| upd_mask_a | input | 6 | Term selection mask for flag A |
| upd_mask_b | input | 6 | Term selection mask for flag B |
| upd_mask_c | input | 6 | Term selection mask for flag C |
| ext_c_load | input | 1 | Load strobe for C from the external source |
| ship_c | input | 1 | C source for the output-direction variant |
| rx_dest | input | DEST_W | Destination address of the received packet (input-direction variant) |
| flag_a | output | 1 | Current flag A |
| flag_b | output | 1 | Current flag B |
| flag_c | output | 1 | Current flag C |

## Verification
The properties assume that `upd_valid`, `ext_c_load`, the masks and `pred_code` are synchronous to `clk` and hold steady across each rising edge. The update qualifier also depends on `pred_code` being the predicate of the same instruction that raises `upd_valid`. Within those limits, any mask value is legal. The stimulus changes every input only at the falling edge and holds it for a whole cycle. It reaches every mask term, predicate codes that are both true and false, and collisions between an update and a C load.

// File: rtl/cond_flag_pkg.sv
package cond_flag_pkg;
    localparam int NUM_FLAGS = 3;
    localparam int MASK_W    = 2 * NUM_FLAGS;

    typedef struct packed {
        logic a;
        logic b;
        logic c;
    } flags_t;

    typedef enum logic [1:0] {
        PRED_A      = 2'b00,
        PRED_C      = 2'b01,
        PRED_B      = 2'b10,
        PRED_ALWAYS = 2'b11
    } pred_e;

    // positions of the selectable terms inside each update mask
    localparam int SEL_A  = 0;
    localparam int SEL_NA = 1;
    localparam int SEL_B  = 2;
    localparam int SEL_NB = 3;
    localparam int SEL_C  = 4;
    localparam int SEL_NC = 5;
endpackage

// File: rtl/cond_pred_eval.sv
module cond_pred_eval
    import cond_flag_pkg::*;
(
    input  logic [1:0] code,
    input  flags_t     flags,
    output logic       hit
);
    always_comb begin
        case (pred_e'(code))
            PRED_A:  hit = flags.a;
            PRED_B:  hit = flags.b;
            PRED_C:  hit = flags.c;
            default: hit = 1'b1;
        endcase
    end
endmodule

// File: rtl/cond_term_or.sv
module cond_term_or
    import cond_flag_pkg::*;
(
    input  logic [MASK_W-1:0] sel,
    input  flags_t            cur,
    output logic              val
);
    logic [MASK_W-1:0] terms;

    always_comb begin
        terms         = '0;
        terms[SEL_A]  = cur.a;
        terms[SEL_NA] = ~cur.a;
        terms[SEL_B]  = cur.b;
        terms[SEL_NB] = ~cur.b;
        terms[SEL_C]  = cur.c;
        terms[SEL_NC] = ~cur.c;
        val           = |(sel & terms);
    end
endmodule

// File: rtl/cond_csrc_sel.sv
module cond_csrc_sel #(
    parameter bit IN_DIR = 1'b1,
    parameter int DEST_W = 8,
    parameter int C_BIT  = DEST_W - 1
) (
    input  logic              ship_c,
    input  logic [DEST_W-1:0] rx_dest,
    output logic              c_src
);
    logic unused_src;
    assign unused_src = ^{ship_c, rx_dest};

    generate
        if (IN_DIR) begin : g_from_addr
            assign c_src = rx_dest[C_BIT];
        end else begin : g_from_ship
            assign c_src = ship_c;
        end
    endgenerate
endmodule

// File: rtl/cond_flag_unit.sv
module cond_flag_unit
    import cond_flag_pkg::*;
#(
    parameter bit IN_DIR = 1'b1,
    parameter int DEST_W = 8,
    parameter int C_BIT  = DEST_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        pred_code,
    output logic              pred_true,
    input  logic              upd_valid,
    input  logic [MASK_W-1:0] upd_mask_a,
    input  logic [MASK_W-1:0] upd_mask_b,
    input  logic [MASK_W-1:0] upd_mask_c,
    input  logic              ext_c_load,
    input  logic              ship_c,
    input  logic [DEST_W-1:0] rx_dest,
    output logic              flag_a,
    output logic              flag_b,
    output logic              flag_c
);
    localparam int C_BIT_OK = (C_BIT >= 0 && C_BIT < DEST_W) ? 1 : 0;

    flags_t state_d, state_q;
    logic   c_src;
    logic   upd_fire;

    logic [NUM_FLAGS-1:0][MASK_W-1:0] mask_all;
    logic [NUM_FLAGS-1:0]             new_vals;

    assign mask_all = {upd_mask_a, upd_mask_b, upd_mask_c};

    cond_pred_eval pred_i (
        .code  (pred_code),
        .flags (state_q),
        .hit   (pred_true)
    );

    generate
        for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_term
            cond_term_or or_i (
                .sel (mask_all[g]),
                .cur (state_q),
                .val (new_vals[g])
            );
        end
    endgenerate

    cond_csrc_sel #(
        .IN_DIR (IN_DIR),
        .DEST_W (DEST_W),
        .C_BIT  (C_BIT_OK ? C_BIT : 0)
    ) csrc_i (
        .ship_c  (ship_c),
        .rx_dest (rx_dest),
        .c_src   (c_src)
    );

    always_comb begin
        upd_fire = upd_valid & pred_true;
        state_d  = state_q;
        if (upd_fire) begin
            state_d = flags_t'(new_vals);
        end else if (ext_c_load) begin
            state_d.c = c_src;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign flag_a = state_q.a;
    assign flag_b = state_q.b;
    assign flag_c = state_q.c;
endmodule

// File: rtl/cond_flag_chk.sv
module cond_flag_chk
    import cond_flag_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              pred_true,
    input logic              upd_valid,
    input logic [MASK_W-1:0] upd_mask_a,
    input logic [MASK_W-1:0] upd_mask_c,
    input logic              ext_c_load,
    input logic              flag_a,
    input logic              flag_b,
    input logic              flag_c
);
    // R1
    reset_zero_chk: assert property (@(posedge clk)
        !rst_n |=> {flag_a, flag_b, flag_c} == 3'b000);

    // R7
    pred_false_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !pred_true && !ext_c_load) |=> $stable({flag_a, flag_b, flag_c}));

    // R4
    empty_mask_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && pred_true && upd_mask_a == '0) |=> !flag_a);

    // R5
    pair_mask_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && pred_true && upd_mask_a[SEL_A] && upd_mask_a[SEL_NA]) |=> flag_a);

    // R10
    update_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && pred_true && ext_c_load && upd_mask_c == '0) |=> !flag_c);

    // R9
    ext_load_keeps_ab_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_valid && ext_c_load) |=> $stable({flag_a, flag_b}));
endmodule

bind cond_flag_unit cond_flag_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .pred_true  (pred_true),
    .upd_valid  (upd_valid),
    .upd_mask_a (upd_mask_a),
    .upd_mask_c (upd_mask_c),
    .ext_c_load (ext_c_load),
    .flag_a     (flag_a),
    .flag_b     (flag_b),
    .flag_c     (flag_c)
);

// File: tb/cond_flag_unit_tb_top.sv
module cond_flag_unit_tb_top;
    localparam int DEST_W = 8;
    localparam int C_BIT  = 7;
    localparam int NV     = 12;
    // fields: [25:24] pred, [23] upd, [22:17] mask A, [16:11] mask B,
    // [10:5] mask C, [4] ext load, [3] C source, [2:0] expected {A,B,C}
    localparam logic [25:0] VECS [NV] = '{
        {2'b11, 1'b1, 6'h03, 6'h00, 6'h00, 1'b0, 1'b0, 3'b100}, // R5 R4
        {2'b11, 1'b1, 6'h01, 6'h08, 6'h01, 1'b0, 1'b0, 3'b111}, // R3
        {2'b11, 1'b1, 6'h02, 6'h04, 6'h10, 1'b0, 1'b0, 3'b011}, // R3
        {2'b11, 1'b1, 6'h04, 6'h01, 6'h20, 1'b0, 1'b0, 3'b100}, // R8 swap
        {2'b10, 1'b1, 6'h00, 6'h03, 6'h30, 1'b0, 1'b0, 3'b100}, // R7 pred false
        {2'b00, 1'b1, 6'h08, 6'h30, 6'h00, 1'b0, 1'b0, 3'b110}, // R2 pred A
        {2'b11, 1'b0, 6'h00, 6'h00, 6'h00, 1'b1, 1'b1, 3'b111}, // R9 load 1
        {2'b01, 1'b1, 6'h01, 6'h04, 6'h10, 1'b0, 1'b0, 3'b111}, // R6 self
        {2'b11, 1'b1, 6'h01, 6'h04, 6'h00, 1'b1, 1'b1, 3'b110}, // R10
        {2'b01, 1'b1, 6'h00, 6'h00, 6'h00, 1'b1, 1'b1, 3'b111}, // R7 R9
        {2'b11, 1'b0, 6'h00, 6'h00, 6'h00, 1'b1, 1'b0, 3'b110}, // R9 load 0
        {2'b11, 1'b0, 6'h3F, 6'h00, 6'h3F, 1'b0, 1'b0, 3'b110}  // R7 no strobe
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        pred_code = 2'b11;
    logic              upd_valid = 1'b0;
    logic [5:0]        upd_mask_a = '0, upd_mask_b = '0, upd_mask_c = '0;
    logic              ext_c_load = 1'b0;
    logic              ship_c = 1'b0;
    logic [DEST_W-1:0] rx_dest = '0;
    logic              pt_i, fa_i, fb_i, fc_i;
    logic              pt_o, fa_o, fb_o, fc_o;
    int                checks = 0;
    int                failures = 0;
    bit                done = 1'b0;

    always #10 clk = ~clk;

    cond_flag_unit #(.IN_DIR(1'b1), .DEST_W(DEST_W), .C_BIT(C_BIT)) dut_i (
        .clk(clk), .rst_n(rst_n), .pred_code(pred_code), .pred_true(pt_i),
        .upd_valid(upd_valid), .upd_mask_a(upd_mask_a), .upd_mask_b(upd_mask_b),
        .upd_mask_c(upd_mask_c), .ext_c_load(ext_c_load), .ship_c(ship_c),
        .rx_dest(rx_dest), .flag_a(fa_i), .flag_b(fb_i), .flag_c(fc_i)
    );

    cond_flag_unit #(.IN_DIR(1'b0), .DEST_W(DEST_W), .C_BIT(C_BIT)) dut_o (
        .clk(clk), .rst_n(rst_n), .pred_code(pred_code), .pred_true(pt_o),
        .upd_valid(upd_valid), .upd_mask_a(upd_mask_a), .upd_mask_b(upd_mask_b),
        .upd_mask_c(upd_mask_c), .ext_c_load(ext_c_load), .ship_c(ship_c),
        .rx_dest(rx_dest), .flag_a(fa_o), .flag_b(fb_o), .flag_c(fc_o)
    );

    task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic set_c_src(input logic v);
        ship_c  = v;
        rx_dest = v ? (DEST_W'(1) << C_BIT) : ~(DEST_W'(1) << C_BIT);
    endtask

    task automatic pred_probe(input string tag, input logic [1:0] code, input logic exp);
        pred_code = code;
        #1;
        check(tag, {2'b00, pt_i}, {2'b00, exp});
        check(tag, {2'b00, pt_o}, {2'b00, exp});
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        set_c_src(1'b1);
        repeat (3) @(negedge clk);
        // R1: reset state and predicates on all-zero flags (R2)
        check("R1 in", {fa_i, fb_i, fc_i}, 3'b000);
        check("R1 out", {fa_o, fb_o, fc_o}, 3'b000);
        pred_probe("R2 zero A", 2'b00, 1'b0);
        pred_probe("R2 zero always", 2'b11, 1'b1);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            pred_code  = VECS[i][25:24];
            upd_valid  = VECS[i][23];
            upd_mask_a = VECS[i][22:17];
            upd_mask_b = VECS[i][16:11];
            upd_mask_c = VECS[i][10:5];
            ext_c_load = VECS[i][4];
            set_c_src(VECS[i][3]);
            @(negedge clk);
            check($sformatf("R3-R10 vec%0d in", i), {fa_i, fb_i, fc_i}, VECS[i][2:0]);
            check($sformatf("R3-R10 vec%0d out", i), {fa_o, fb_o, fc_o}, VECS[i][2:0]);
            upd_valid  = 1'b0;
            ext_c_load = 1'b0;
        end

        // R2: flags now A=1 B=1 C=0
        pred_probe("R2 A set", 2'b00, 1'b1);
        pred_probe("R2 B set", 2'b10, 1'b1);
        pred_probe("R2 C clear", 2'b01, 1'b0);

        // R4 R5: A<-0, B<-0, C<-1
        @(negedge clk);
        pred_code = 2'b11; upd_valid = 1'b1;
        upd_mask_a = 6'h00; upd_mask_b = 6'h00; upd_mask_c = 6'h30;
        @(negedge clk);
        upd_valid = 1'b0;
        check("R4 R5 in", {fa_i, fb_i, fc_i}, 3'b001);
        check("R4 R5 out", {fa_o, fb_o, fc_o}, 3'b001);
        pred_probe("R2 A clear", 2'b00, 1'b0);
        pred_probe("R2 B clear", 2'b10, 1'b0);
        pred_probe("R2 C set", 2'b01, 1'b1);
        pred_probe("R2 always", 2'b11, 1'b1);

        // R9: per-variant source, sources disagree
        ext_c_load = 1'b1; ship_c = 1'b1; rx_dest = ~(DEST_W'(1) << C_BIT);
        @(negedge clk);
        ext_c_load = 1'b0;
        check("R9 addr bit", {fa_i, fb_i, fc_i}, 3'b000);
        check("R9 ship", {fa_o, fb_o, fc_o}, 3'b001);

        // R1: reset mid-run
        rst_n = 1'b0;
        #1;
        check("R1 midrun in", {fa_i, fb_i, fc_i}, 3'b000);
        check("R1 midrun out", {fa_o, fb_o, fc_o}, 3'b000);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule